// File: doc/BRIEF.md
# Dual-Band Multimodulus Prescaler

This block divides a fast input clock by one of four ratios: 32, 33, 47 or 48. Its front stage is a divide-by-2/3 cell. A chain of four toggle stages follows the cell and divides its output by a fixed 16. A small glue stage decides which ratio the cell uses in each of its 16 slots. In one slot per output period the cell runs the "other" ratio, and that sets the total.

A band input selects the pair. With band at 0 the pair is 32/33. With band at 1 the glue inverts the cell's mode control, which gives 47/48, and no extra flip-flops are needed for this. A modulus input picks a ratio inside the pair. A swallow counter normally drives it: 0 means N+1 and 1 means N.

The block has three outputs. The divided clock is the last chain stage. A one-cycle terminal pulse marks the last input cycle of every output period. A status flag reports whether the cell's first flip-flop is idle in the current slot. The controls are sampled once, at the start of each output period.

Top module: `mmp_prescaler`

## Requirements
- R1: With band_hi_i=0 and modulus_i=1, period_end_o pulses every 32 input clock cycles.
- R2: With band_hi_i=0 and modulus_i=0, period_end_o pulses every 33 input clock cycles.
- R3: With band_hi_i=1 and modulus_i=1, period_end_o pulses every 47 input clock cycles.
- R4: With band_hi_i=1 and modulus_i=0, period_end_o pulses every 48 input clock cycles.
- R5: period_end_o is high for exactly one cycle per period. div_clk_o is high in that cycle and low in the cycle after it.
- R6: band_hi_i and modulus_i are sampled only in the first cycle of each output period. A change made later in a period leaves that period's length unchanged and applies to the next period.
- R7: While rst_ni is low, period_end_o and div_clk_o are 0. After release, the first period_end_o appears after N-1 rising edges, where N is the ratio selected by the inputs present at release.
- R8: first_stage_idle_o is high in every cycle in which the 2/3 cell divides by 2. Per period it is low for 0 cycles at ratio 32, 3 cycles at 33, 45 cycles at 47 and 48 cycles at 48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-rate input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| band_hi_i | input | 1 | 0 selects the 32/33 pair, 1 selects the 47/48 pair |
| modulus_i | input | 1 | 0 selects N+1 (33 or 48), 1 selects N (32 or 47) |
| div_clk_o | output | 1 | Divided clock (last toggle stage) |
| period_end_o | output | 1 | One-cycle pulse in the last input cycle of each period |
| first_stage_idle_o | output | 1 | High while the 2/3 cell's first flip-flop is not needed |

## Verification
A wrong cell count or a misplaced swallow slot changes the spacing of the terminal pulses. That shows up within a single output period, as a gap of the wrong length or as an idle-flag busy count off its expected value. A control register that updates in the middle of a period shows up as one period of a mixed length. The bench therefore times each gap and the busy count separately, for all four control combinations, for the first period after reset, and across a mid-period control change.

// File: rtl/mmp_pkg.sv
package mmp_pkg;
  localparam int unsigned CELL_CNT_W = 2;
  typedef struct packed {
    logic band_hi;
    logic modulus;
  } mmp_ctrl_t;
endpackage

// File: rtl/mmp_cell23.sv
module mmp_cell23
  import mmp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div3_i,
  output logic tick_o,
  output logic slot_start_o
);
  logic [CELL_CNT_W-1:0] cnt_q;

  assign tick_o       = div3_i ? (cnt_q == CELL_CNT_W'(2)) : (cnt_q == CELL_CNT_W'(1));
  assign slot_start_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CELL_CNT_W'(1);
  end

  AST_CELL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != CELL_CNT_W'(3)); // R4
  AST_CELL_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> slot_start_o); // R1
endmodule

// File: rtl/mmp_toggle_chain.sv
module mmp_toggle_chain #(
  parameter int unsigned NSTAGE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [NSTAGE-1:0] q_o,
  output logic              all_ones_o
);
  logic [NSTAGE:0] carry;
  assign carry[0] = en_i;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    logic q_q;
    assign carry[i+1] = carry[i] & q_q;
    assign q_o[i]     = q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_q <= 1'b0;
      else if (carry[i]) q_q <= ~q_q;
    end
  end

  assign all_ones_o = &q_o;

  AST_CHAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o)); // R5
endmodule

// File: rtl/mmp_mode_glue.sv
module mmp_mode_glue
  import mmp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic band_hi_i,
  input  logic modulus_i,
  input  logic period_start_i,
  input  logic last_slot_i,
  output logic div3_o,
  output logic idle_o
);
  mmp_ctrl_t held_q, eff;
  logic swallow, mc;

  // live inputs in the start cycle, held copy for the rest of the period
  assign eff = period_start_i ? mmp_ctrl_t'{band_hi: band_hi_i, modulus: modulus_i} : held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             held_q <= '0;
    else if (period_start_i) held_q <= eff;
  end

  // modulus sense aligned per band so that 0 always means N+1
  assign swallow = eff.band_hi ? eff.modulus : ~eff.modulus;
  assign mc      = ~(swallow & last_slot_i);
  assign div3_o  = eff.band_hi ? mc : ~mc;
  assign idle_o  = ~div3_o;

  AST_CTRL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_start_i |=> $stable(held_q)); // R6
  AST_ONE_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!last_slot_i && !eff.band_hi) |-> idle_o); // R8
endmodule

// File: rtl/mmp_prescaler.sv
module mmp_prescaler #(
  parameter int unsigned NSTAGE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic band_hi_i,
  input  logic modulus_i,
  output logic div_clk_o,
  output logic period_end_o,
  output logic first_stage_idle_o
);
  logic              div3, tick, slot_start, all_ones, period_start;
  logic [NSTAGE-1:0] chain_q;

  mmp_cell23 u_cell (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .div3_i       (div3),
    .tick_o       (tick),
    .slot_start_o (slot_start)
  );

  mmp_toggle_chain #(.NSTAGE(NSTAGE)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (tick),
    .q_o        (chain_q),
    .all_ones_o (all_ones)
  );

  assign period_start = slot_start & (chain_q == '0);

  mmp_mode_glue u_glue (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .band_hi_i      (band_hi_i),
    .modulus_i      (modulus_i),
    .period_start_i (period_start),
    .last_slot_i    (all_ones),
    .div3_o         (div3),
    .idle_o         (first_stage_idle_o)
  );

  assign period_end_o = tick & all_ones;
  assign div_clk_o    = chain_q[NSTAGE-1];

  AST_END_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |=> period_start); // R5
  AST_END_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |=> !period_end_o); // R5
  AST_END_CLK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_o |=> !div_clk_o); // R5
endmodule

// File: tb/sim_mmp_prescaler.sv
module sim_mmp_prescaler;
  localparam time CLK_PERIOD = 10ns;
  // {band, modulus, period, busy cycles}
  localparam logic [17:0] VEC [4] = '{
    {1'b0, 1'b1, 8'd32, 8'd0},
    {1'b0, 1'b0, 8'd33, 8'd3},
    {1'b1, 1'b1, 8'd47, 8'd45},
    {1'b1, 1'b0, 8'd48, 8'd48}
  };

  logic clk = 1'b0, rst_n = 1'b0, band = 1'b0, modn = 1'b1;
  logic div_clk, pend, idle;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmp_prescaler u0 (
    .clk_i(clk), .rst_ni(rst_n), .band_hi_i(band), .modulus_i(modn),
    .div_clk_o(div_clk), .period_end_o(pend), .first_stage_idle_o(idle)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts negedges up to and including the next pulse
  task automatic measure(output int len, output int busy, output int clk_hi_at_end);
    len = 0; busy = 0; clk_hi_at_end = 0;
    while (1) begin
      @(negedge clk);
      len++;
      if (!idle) busy++;
      if (pend) begin clk_hi_at_end = int'(div_clk); break; end
      if (len > 200) break;
    end
  endtask

  initial begin
    int len, busy, hi;
    // reset state (R7)
    repeat (3) @(negedge clk);
    check("R7 pend in reset", int'(pend), 0);
    check("R7 div_clk in reset", int'(div_clk), 0);

    for (int v = 0; v < 4; v++) begin
      string rq;
      int p, b;
      rq = (v == 0) ? "R1" : (v == 1) ? "R2" : (v == 2) ? "R3" : "R4";
      p = int'(VEC[v][15:8]);
      b = int'(VEC[v][7:0]);
      @(negedge clk); rst_n = 1'b0; band = VEC[v][17]; modn = VEC[v][16];
      @(negedge clk); rst_n = 1'b1;
      measure(len, busy, hi);
      check({"R7 first period ", rq}, len, p - 1);
      for (int k = 0; k < 3; k++) begin
        measure(len, busy, hi);
        check({rq, " period"}, len, p);
        check({"R8 busy ", rq}, busy, b);
        check({"R5 div_clk high at pulse ", rq}, hi, 1);
        @(negedge clk);
        check({"R5 pulse one cycle ", rq}, int'(pend), 0);
        check({"R5 div_clk low after pulse ", rq}, int'(div_clk), 0);
        if (k == 2) break;
        // compensate the extra negedge consumed above
        measure(len, busy, hi);
        check({rq, " period after pulse"}, len + 1, p);
      end
    end

    // mid-period control change (R6)
    @(negedge clk); rst_n = 1'b0; band = 1'b0; modn = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    measure(len, busy, hi);
    repeat (10) @(negedge clk);
    band = 1'b1; modn = 1'b0;
    measure(len, busy, hi);
    check("R6 current period unchanged", len + 10, 32);
    measure(len, busy, hi);
    check("R6 next period uses new controls", len, 48);
    check("R8 busy after switch", busy, 48);

    // change in start cycle is taken (R6)
    band = 1'b0; modn = 1'b0;
    measure(len, busy, hi);
    check("R6 start-cycle sample", len, 33);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule